// File: doc/BRIEF.md
# Power Supply Supervisor Sequencer

This block sequences the main converter of a PC power supply and reports when its outputs are usable. It takes already digitized comparator flags: a remote request (low asks for operation, high asks for shutdown), an over-voltage and an under-voltage flag for each monitored positive rail, an over-power flag, a negative-rail fault flag and an AC-fail flag. From these it drives a converter enable, which releases soft-start, and an active-high power-good output.

Every delay counts pulses of a single time-base strobe, `tick`, and each length is a parameter. A remote request must be held for the whole turn-on or turn-off delay before it is acted on. Once the converter runs and the rails are judged good, power-good follows after its own delay. On an accepted shutdown, power-good drops first and the converter stops a fixed interval later. Each fault flag must persist for its own qualification time. AC-fail only withholds power-good. Every other fault latches the converter off until the remote input goes high. Under-voltage and negative-rail checks are masked while soft-start is still in progress. A cause vector records which faults tripped the latch.

Top module: `psu_supervisor`

## Requirements
- R1: While reset is held and directly after it, `conv_en` and `pwr_good` are 0 and `trip_cause` is all zeros.
- R2: `conv_en` rises only after `remote_off` has stayed low for ON_DLY ticks; a low pulse that is shorter leaves `conv_en` at 0.
- R3: With the converter enabled, no raw under-voltage flag and no qualified AC-fail, `pwr_good` rises PG_DLY ticks later; `pwr_good` is never 1 while `conv_en` is 0.
- R4: A high pulse on `remote_off` shorter than OFF_DLY ticks while running changes neither output.
- R5: A high level on `remote_off` that lasts OFF_DLY ticks first drops `pwr_good`, and `conv_en` falls PGOFF_DLY ticks after that.
- R6: `acfail` held for AC_QUAL ticks drops `pwr_good` but leaves `conv_en` at 1; a shorter pulse has no effect; once it clears, `pwr_good` returns after PG_DLY ticks.
- R7: An over-voltage flag on any rail held for OV_QUAL ticks, or `opp_flt` held for OPP_QUAL ticks, drops `conv_en` and `pwr_good` together and latches them off.
- R8: An under-voltage flag held for UV_QUAL ticks, or `neg_flt` held for NEG_QUAL ticks, latches the converter off. Both are ignored until SS_BLANK ticks have passed since `conv_en` rose; a shorter `neg_flt` pulse is also ignored.
- R9: Once latched off, the block stays off for as long as `remote_off` is low. A high level on `remote_off` clears the latch, and a later low request powers up again through the full turn-on delay.
- R10: `trip_cause` captures every qualified fault on the cycle the latch trips. Bit i is an over-voltage on rail i and bit NRAIL+i is an under-voltage on rail i. Bit 2*NRAIL is over-power and bit 2*NRAIL+1 is the negative-rail fault. The vector holds while latched and clears with the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base strobe, one cycle per delay unit |
| remote_off | input | 1 | Remote request: 0 asks for operation, 1 asks for shutdown and clears the latch |
| ov_flt | input | NRAIL | Over-voltage flag per rail |
| uv_flt | input | NRAIL | Under-voltage flag per rail |
| opp_flt | input | 1 | Over-power / short-circuit flag |
| neg_flt | input | 1 | Negative-rail fault flag |
| acfail | input | 1 | AC line failure flag |
| conv_en | output | 1 | Main converter enable (soft-start release) |
| pwr_good | output | 1 | Active-high power-good |
| trip_cause | output | 2*NRAIL+2 | Faults captured when the latch tripped |

## Verification
The bench targets the filter boundaries: pulses a little shorter than each qualification or request delay, which a persistence counter that fails to restart would wrongly accept. It checks that power-good leads the converter off on a shutdown; a design that dropped both together would fail the early sample in which power-good is 0 and the enable is still 1. It drives an under-voltage flag during soft-start, which a block without the blanking window would latch on. It also makes sure an AC-fail never disables the converter. Finally, it holds the remote request low after a trip to catch a latch that releases too early, and it reads the cause vector for a bit placed at the wrong position or left set after the latch clears.

// File: rtl/psu_sup_pkg.sv
package psu_sup_pkg;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_ONWAIT  = 3'd1,
    ST_RAMP    = 3'd2,
    ST_GOOD    = 3'd3,
    ST_PGDROP  = 3'd4,
    ST_LATCH   = 3'd5
  } sup_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/psu_persist.sv
// Persistence filter: hit goes high once flag has been high (while armed)
// for LIM time-base ticks; any drop of flag or arm restarts the count.
module psu_persist #(
  parameter int LIM = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic arm,
  input  logic flag,
  output logic hit
);
  localparam int CW = $clog2(LIM + 1);
  localparam logic [CW-1:0] LIM_C = CW'(LIM);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!arm || !flag)                cnt_d = '0;
    else if (tick && cnt_q != LIM_C)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit = (cnt_q == LIM_C);
endmodule

// File: rtl/psu_seq_fsm.sv
module psu_seq_fsm
  import psu_sup_pkg::*;
#(
  parameter int NF        = 8,
  parameter int ON_DLY    = 10,
  parameter int PG_DLY    = 12,
  parameter int PGOFF_DLY = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          remote_off,
  input  logic          off_q,
  input  logic          ac_q,
  input  logic          uv_raw,
  input  logic [NF-1:0] fault_vec,
  output logic          conv_en,
  output logic          pwr_good,
  output logic          running,
  output logic [NF-1:0] trip_cause
);
  localparam int TMAX = max3(ON_DLY, PG_DLY, PGOFF_DLY);
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] TSAT = TW'(TMAX);

  sup_state_e    st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          tmr_clr;
  logic [NF-1:0] cause_q, cause_d;
  logic          fault_any;

  assign fault_any = |fault_vec;

  always_comb begin
    st_d    = st_q;
    tmr_clr = 1'b0;
    unique case (st_q)
      ST_OFF:    if (!remote_off) st_d = ST_ONWAIT;
      ST_ONWAIT: begin
        if (remote_off)                   st_d = ST_OFF;
        else if (tmr_q == TW'(ON_DLY))    st_d = ST_RAMP;
      end
      ST_RAMP: begin
        if (fault_any)                    st_d = ST_LATCH;
        else if (off_q)                   st_d = ST_PGDROP;
        else if (uv_raw || ac_q)          tmr_clr = 1'b1;
        else if (tmr_q == TW'(PG_DLY))    st_d = ST_GOOD;
      end
      ST_GOOD: begin
        if (fault_any)                    st_d = ST_LATCH;
        else if (off_q)                   st_d = ST_PGDROP;
        else if (ac_q)                    st_d = ST_RAMP;
      end
      ST_PGDROP: begin
        if (fault_any)                    st_d = ST_LATCH;
        else if (tmr_q == TW'(PGOFF_DLY)) st_d = ST_OFF;
      end
      ST_LATCH:  if (remote_off) st_d = ST_OFF;
      default:   st_d = ST_OFF;
    endcase
  end

  always_comb begin
    tmr_d = tmr_q;
    if (tmr_clr || st_d != st_q)      tmr_d = '0;
    else if (tick && tmr_q != TSAT)   tmr_d = tmr_q + 1'b1;
  end

  always_comb begin
    cause_d = '0;
    if (st_d == ST_LATCH)
      cause_d = (st_q == ST_LATCH) ? cause_q : fault_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OFF;
      tmr_q   <= '0;
      cause_q <= '0;
    end else begin
      st_q    <= st_d;
      tmr_q   <= tmr_d;
      cause_q <= cause_d;
    end
  end

  assign conv_en    = (st_q == ST_RAMP) || (st_q == ST_GOOD) || (st_q == ST_PGDROP);
  assign pwr_good   = (st_q == ST_GOOD);
  assign running    = (st_q == ST_RAMP) || (st_q == ST_GOOD);
  assign trip_cause = cause_q;
endmodule

// File: rtl/psu_supervisor.sv
module psu_supervisor #(
  parameter int NRAIL     = 3,
  parameter int ON_DLY    = 50,
  parameter int OFF_DLY   = 16,
  parameter int PG_DLY    = 300,
  parameter int PGOFF_DLY = 2,
  parameter int SS_BLANK  = 20,
  parameter int AC_QUAL   = 2,
  parameter int OV_QUAL   = 1,
  parameter int UV_QUAL   = 2,
  parameter int OPP_QUAL  = 1,
  parameter int NEG_QUAL  = 7,
  localparam int NF       = 2 * NRAIL + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             remote_off,
  input  logic [NRAIL-1:0] ov_flt,
  input  logic [NRAIL-1:0] uv_flt,
  input  logic             opp_flt,
  input  logic             neg_flt,
  input  logic             acfail,
  output logic             conv_en,
  output logic             pwr_good,
  output logic [NF-1:0]    trip_cause
);
  logic          ss_done, off_q, ac_q, running;
  logic          chk_late;
  logic [NF-1:0] fault_vec;

  // soft-start window: counts ticks since conv_en rose
  psu_persist #(.LIM(SS_BLANK)) i_ss (
    .clk(clk), .rst_n(rst_n), .tick(tick), .arm(1'b1), .flag(conv_en), .hit(ss_done));

  assign chk_late = conv_en && ss_done;

  psu_persist #(.LIM(OFF_DLY)) i_offq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .arm(running), .flag(remote_off), .hit(off_q));

  psu_persist #(.LIM(AC_QUAL)) i_acq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .arm(1'b1), .flag(acfail), .hit(ac_q));

  for (genvar r = 0; r < NRAIL; r++) begin : g_rail
    psu_persist #(.LIM(OV_QUAL)) i_ov (
      .clk(clk), .rst_n(rst_n), .tick(tick), .arm(conv_en), .flag(ov_flt[r]),
      .hit(fault_vec[r]));
    psu_persist #(.LIM(UV_QUAL)) i_uv (
      .clk(clk), .rst_n(rst_n), .tick(tick), .arm(chk_late), .flag(uv_flt[r]),
      .hit(fault_vec[NRAIL + r]));
  end

  psu_persist #(.LIM(OPP_QUAL)) i_opp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .arm(conv_en), .flag(opp_flt),
    .hit(fault_vec[2 * NRAIL]));

  psu_persist #(.LIM(NEG_QUAL)) i_neg (
    .clk(clk), .rst_n(rst_n), .tick(tick), .arm(chk_late), .flag(neg_flt),
    .hit(fault_vec[2 * NRAIL + 1]));

  psu_seq_fsm #(.NF(NF), .ON_DLY(ON_DLY), .PG_DLY(PG_DLY), .PGOFF_DLY(PGOFF_DLY)) i_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .remote_off(remote_off),
    .off_q(off_q), .ac_q(ac_q), .uv_raw(|uv_flt), .fault_vec(fault_vec),
    .conv_en(conv_en), .pwr_good(pwr_good), .running(running), .trip_cause(trip_cause));
endmodule

// File: rtl/psu_supervisor_chk.sv
module psu_supervisor_chk #(
  parameter int NF = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          remote_off,
  input logic          conv_en,
  input logic          pwr_good,
  input logic [NF-1:0] trip_cause
);
  // R3
  pg_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_good |-> conv_en);

  // R2
  en_rise_on_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_en) |-> $past(!remote_off));

  // R7
  latched_no_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_cause != '0) |-> !pwr_good);

  // R10
  cause_only_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_cause != '0) |-> !conv_en);

  // R9
  latch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((trip_cause != '0) && !remote_off) |=> $stable(trip_cause));
endmodule

bind psu_supervisor psu_supervisor_chk #(.NF(2 * NRAIL + 2)) i_chk (
  .clk(clk), .rst_n(rst_n), .remote_off(remote_off), .conv_en(conv_en),
  .pwr_good(pwr_good), .trip_cause(trip_cause));

// File: tb/test_psu_supervisor.sv
module test_psu_supervisor;
  localparam int NRAIL = 3, NF = 2 * NRAIL + 2;
  localparam int ON_DLY = 10, OFF_DLY = 6, PG_DLY = 12, PGOFF_DLY = 4, SS_BLANK = 8;
  localparam int AC_QUAL = 3, OV_QUAL = 2, UV_QUAL = 3, OPP_QUAL = 2, NEG_QUAL = 5;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic remote_off = 1'b1, opp_flt = 1'b0, neg_flt = 1'b0, acfail = 1'b0;
  logic [NRAIL-1:0] ov_flt = '0, uv_flt = '0;
  logic conv_en, pwr_good;
  logic [NF-1:0] trip_cause;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;
  always @(posedge clk) tick <= rst_n ? ~tick : 1'b0;

  psu_supervisor #(.NRAIL(NRAIL), .ON_DLY(ON_DLY), .OFF_DLY(OFF_DLY), .PG_DLY(PG_DLY),
    .PGOFF_DLY(PGOFF_DLY), .SS_BLANK(SS_BLANK), .AC_QUAL(AC_QUAL), .OV_QUAL(OV_QUAL),
    .UV_QUAL(UV_QUAL), .OPP_QUAL(OPP_QUAL), .NEG_QUAL(NEG_QUAL)) i_psu_supervisor (
    .clk(clk), .rst_n(rst_n), .tick(tick), .remote_off(remote_off), .ov_flt(ov_flt),
    .uv_flt(uv_flt), .opp_flt(opp_flt), .neg_flt(neg_flt), .acfail(acfail),
    .conv_en(conv_en), .pwr_good(pwr_good), .trip_cause(trip_cause));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (2 * n) @(negedge clk);
  endtask

  task automatic outs(input string req, input int en, input int pg, input int cause);
    chk({req, " conv_en"}, int'(conv_en), en);
    chk({req, " pwr_good"}, int'(pwr_good), pg);
    chk({req, " trip_cause"}, int'(trip_cause), cause);
  endtask

  // from off: full power-up to power-good
  task automatic power_up();
    remote_off = 1'b0;
    wait_ticks(ON_DLY - 1);
    outs("R2 before on delay", 0, 0, 0);
    wait_ticks(3);
    outs("R2 after on delay", 1, 0, 0);
    wait_ticks(PG_DLY - 3);
    outs("R3 before pg delay", 1, 0, 0);
    wait_ticks(4);
    outs("R3 after pg delay", 1, 1, 0);
  endtask

  task automatic clear_latch(input int cause);
    wait_ticks(20);
    outs("R9 latch holds with request low", 0, 0, cause);
    remote_off = 1'b1;
    wait_ticks(2);
    outs("R10 cause clears with latch", 0, 0, 0);
  endtask

  task automatic t_reset();
    outs("R1 during reset", 0, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    wait_ticks(3);
    outs("R1 after reset", 0, 0, 0);
  endtask

  task automatic t_short_on();
    remote_off = 1'b0;
    wait_ticks(ON_DLY - 3);
    remote_off = 1'b1;
    wait_ticks(ON_DLY + 4);
    outs("R2 short on request ignored", 0, 0, 0);
  endtask

  task automatic t_acfail();
    acfail = 1'b1; wait_ticks(AC_QUAL - 1); acfail = 1'b0;
    wait_ticks(2);
    outs("R6 short acfail ignored", 1, 1, 0);
    acfail = 1'b1; wait_ticks(AC_QUAL + 3);
    outs("R6 acfail drops pg only", 1, 0, 0);
    acfail = 1'b0;
    wait_ticks(PG_DLY - 2);
    outs("R6 pg still low while delaying", 1, 0, 0);
    wait_ticks(5);
    outs("R6 pg back after delay", 1, 1, 0);
  endtask

  task automatic t_off_seq();
    remote_off = 1'b1; wait_ticks(OFF_DLY - 2); remote_off = 1'b0;
    wait_ticks(3);
    outs("R4 short off request ignored", 1, 1, 0);
    remote_off = 1'b1;
    wait_ticks(OFF_DLY + 2);
    outs("R5 pg drops before converter", 1, 0, 0);
    wait_ticks(PGOFF_DLY + 2);
    outs("R5 converter off after gap", 0, 0, 0);
  endtask

  task automatic t_uv();
    remote_off = 1'b0;
    wait_ticks(ON_DLY + 2);
    uv_flt = 3'b010;
    wait_ticks(SS_BLANK - 3);
    uv_flt = '0;
    wait_ticks(PG_DLY + 4);
    outs("R8 uv ignored during soft-start", 1, 1, 0);
    uv_flt = 3'b010;
    wait_ticks(UV_QUAL + 2);
    uv_flt = '0;
    outs("R8 uv rail1 latches off, R10 bit NRAIL+1", 0, 0, 32'h10);
    clear_latch(32'h10);
  endtask

  task automatic t_ov_opp();
    power_up();
    ov_flt = 3'b100; wait_ticks(OV_QUAL + 2); ov_flt = '0;
    outs("R7 ov rail2 latches, R10 bit 2", 0, 0, 32'h04);
    clear_latch(32'h04);
    power_up();
    opp_flt = 1'b1; wait_ticks(OPP_QUAL + 2); opp_flt = 1'b0;
    outs("R7 over-power latches, R10 bit 2*NRAIL", 0, 0, 32'h40);
    clear_latch(32'h40);
  endtask

  task automatic t_neg();
    power_up();
    neg_flt = 1'b1; wait_ticks(NEG_QUAL - 2); neg_flt = 1'b0;
    wait_ticks(2);
    outs("R8 short neg fault ignored", 1, 1, 0);
    neg_flt = 1'b1; wait_ticks(NEG_QUAL + 2); neg_flt = 1'b0;
    outs("R8 neg fault latches, R10 bit 2*NRAIL+1", 0, 0, 32'h80);
    clear_latch(32'h80);
    power_up();
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_short_on();
    power_up();
    t_acfail();
    t_off_seq();
    t_uv();
    t_ov_opp();
    t_neg();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule